// File: doc/BRIEF.md
# Dual-Channel Serial DAC Write Sequencer

This block is the host-side engine that writes a dual-channel, current-output serial DAC over a three-wire link: an active-low chip select, a serial clock and a data line. A fourth line, an active-low load strobe, moves the DAC's staged values to its outputs. A command port with a valid/ready handshake accepts one update request at a time. Each request carries an update mode, a two-bit channel address and one or two data words. The engine turns the request into correctly timed serial frames.

In immediate mode the load strobe is held low, so the DAC output follows the frame as soon as chip select rises. One frame is sent, using the caller's address unchanged.

In synchronized mode the engine raises the load strobe and writes channel A and then channel B, each as its own frame. It then pulses the strobe low once, so both outputs move on the same edge. Every interval is a parameter counted in system clocks: the serial clock half-period, the chip-select hold after the last clock, the minimum chip-select high gap, the strobe setup gap and the strobe pulse width. An optional byte mode pads each frame with leading zeros to a whole number of bytes.

Top module: `dacwr_ctrl`

## Requirements
- R1: Out of reset, and whenever idle, chip select is high, the serial clock is low and the command port is ready. The load strobe is high after reset.
- R2: A frame is sent MSB first. Its bits are the two address bits (upper one first), then the data word MSB first. Chip select stays low for exactly the frame's bit count of rising serial-clock edges: DATA_W+2 bits without byte mode.
- R3: The data line changes only while the serial clock is low, on the clock's falling edge. It is stable for at least one system clock before each rising edge and through the whole high phase.
- R4: Each high phase and each low phase of the serial clock that precedes a rising edge lasts at least HALF_CYC system clocks.
- R5: Chip select rises only while the serial clock is low. It rises no sooner than CS_HOLD system clocks after the serial clock's last falling edge.
- R6: In immediate mode (cmd_sync=0) exactly one frame carries cmd_addr and cmd_data, and the load strobe is low when chip select rises. Address codes 00, 01, 10 and 11 are all sent as given.
- R7: In synchronized mode (cmd_sync=1) cmd_addr is ignored. Two frames are sent: the first with address 01 and cmd_data, the second with address 10 and cmd_data_b. The load strobe is high at both chip-select rises. After the second frame it falls exactly once, stays low at least LD_W clocks and ends high.
- R8: The command is taken on a clock edge where cmd_valid and cmd_ready are both high. cmd_ready then stays low until the sequence ends. Command inputs that change while busy, including a held cmd_valid, have no effect. With the defaults, ready stays low for 78 clocks for an immediate command and 158 for a synchronized one.
- R9: With BYTE_MODE=1 each frame is 24 bits for DATA_W=16, with six leading zero bits ahead of the address.
- R10: Between two frames, chip select stays high for at least CS_GAP system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_sync | input | 1 | 0 = immediate update, 1 = synchronized A then B |
| cmd_addr | input | 2 | Channel address for immediate mode (01 A, 10 B, 11 both, 00 none) |
| cmd_data | input | DATA_W | Data word (channel A word in synchronized mode) |
| cmd_data_b | input | DATA_W | Channel B word in synchronized mode |
| dac_csn | output | 1 | Active-low chip select |
| dac_sclk | output | 1 | Serial clock, idle low |
| dac_sdi | output | 1 | Serial data, changes on falling clock edges |
| dac_ldacn | output | 1 | Active-low load strobe |

## Verification
The bench decodes the serial lines with its own monitor. It looks at data that moves during a high phase or too close to a rising edge, which a design shifting on the rising edge would show as setup failures. It also looks at chip select rising with the clock high or too soon after the last falling edge. For synchronized commands it checks that the load strobe stays high through both frames and pulses exactly once after the second. A design that pulsed after each frame, or left the strobe low, would show the wrong pulse count or wrong levels at chip-select rise. Other checks cover padding in byte mode, a held valid during a busy period, address codes 00 and 11, a switch from synchronized back to immediate mode, and a reset mid-frame.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_NONE = 2'b00;
    localparam logic [ADDR_W-1:0] ADDR_A    = 2'b01;
    localparam logic [ADDR_W-1:0] ADDR_B    = 2'b10;
    localparam logic [ADDR_W-1:0] ADDR_BOTH = 2'b11;

    typedef enum logic {
        MODE_IMM  = 1'b0,
        MODE_SYNC = 1'b1
    } upd_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP,
        ST_LDLO,
        ST_POST
    } seq_state_t;

    typedef struct packed {
        logic csn;
        logic sclk;
        logic ldacn;
    } ctl_pins_t;

    function automatic int frame_len(input int data_w, input int byte_mode);
        int f;
        f = data_w + ADDR_W;
        return (byte_mode != 0) ? ((f + 7) / 8) * 8 : f;
    endfunction

    function automatic int max5(input int a, input int b, input int c,
                                input int d, input int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/dacwr_timer.sv
module dacwr_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/dacwr_shifter.sv
module dacwr_shifter #(
    parameter int TOT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TOT_W-1:0] load_word,
    input  logic             advance,
    output logic             sdi,
    output logic             last
);

    localparam int CW = (TOT_W > 1) ? $clog2(TOT_W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(TOT_W - 1);

    logic [TOT_W-1:0] sh;
    logic [CW-1:0]    idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            idx <= '0;
        end else if (load) begin
            sh  <= load_word;
            idx <= '0;
        end else if (advance) begin
            sh  <= {sh[TOT_W-2:0], 1'b0};
            idx <= idx + 1'b1;
        end
    end

    assign sdi  = sh[TOT_W-1];
    assign last = (idx == LAST_IDX);

    AST_NO_SHIFT_PAST_END: assert property (@(posedge clk) disable iff (rst)
        advance |-> !last) else $error("shift past frame end"); // R2

endmodule

// File: rtl/dacwr_seq.sv
module dacwr_seq
    import dacwr_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int CS_HOLD  = 2,
    parameter int CS_GAP   = 2,
    parameter int LD_GAP   = 2,
    parameter int LD_W     = 2,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  upd_mode_t        cmd_mode,
    output logic             cmd_ready,
    input  logic             t_done,
    input  logic             sh_last,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             sh_load,
    output logic             sh_sel_b,
    output logic             sh_adv,
    output ctl_pins_t        pins
);

    localparam logic [CNT_W-1:0] T_HALF = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] T_HOLD = CNT_W'(CS_HOLD - 1);
    localparam logic [CNT_W-1:0] T_GAP  = CNT_W'(CS_GAP - 1);
    localparam logic [CNT_W-1:0] T_LDG  = CNT_W'(LD_GAP - 1);
    localparam logic [CNT_W-1:0] T_LDW  = CNT_W'(LD_W - 1);

    seq_state_t state;
    upd_mode_t  mode_q;
    logic       second;
    ctl_pins_t  pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            mode_q      <= MODE_IMM;
            second      <= 1'b0;
            pin_q.csn   <= 1'b1;
            pin_q.sclk  <= 1'b0;
            pin_q.ldacn <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    mode_q      <= cmd_mode;
                    second      <= 1'b0;
                    pin_q.ldacn <= (cmd_mode == MODE_SYNC);
                    state       <= ST_PRE;
                end
                ST_PRE: if (t_done) begin
                    pin_q.csn <= 1'b0;
                    state     <= ST_SHIFT;
                end
                ST_SHIFT: if (t_done) begin
                    if (!pin_q.sclk) begin
                        pin_q.sclk <= 1'b1;
                    end else begin
                        pin_q.sclk <= 1'b0;
                        if (sh_last) state <= ST_HOLD;
                    end
                end
                ST_HOLD: if (t_done) begin
                    pin_q.csn <= 1'b1;
                    state     <= ST_GAP;
                end
                ST_GAP: if (t_done) begin
                    if (mode_q == MODE_SYNC && !second) begin
                        second    <= 1'b1;
                        pin_q.csn <= 1'b0;
                        state     <= ST_SHIFT;
                    end else if (mode_q == MODE_SYNC) begin
                        pin_q.ldacn <= 1'b0;
                        state       <= ST_LDLO;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_LDLO: if (t_done) begin
                    pin_q.ldacn <= 1'b1;
                    state       <= ST_POST;
                end
                ST_POST: if (t_done) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        t_load   = 1'b0;
        t_val    = '0;
        sh_load  = 1'b0;
        sh_sel_b = 1'b0;
        sh_adv   = 1'b0;
        case (state)
            ST_IDLE: if (cmd_valid) begin
                t_load  = 1'b1;
                t_val   = T_LDG;
                sh_load = 1'b1;
            end
            ST_PRE: if (t_done) begin
                t_load = 1'b1;
                t_val  = T_HALF;
            end
            ST_SHIFT: if (t_done) begin
                t_load = 1'b1;
                t_val  = (pin_q.sclk && sh_last) ? T_HOLD : T_HALF;
                sh_adv = pin_q.sclk && !sh_last;
            end
            ST_HOLD: if (t_done) begin
                t_load = 1'b1;
                t_val  = T_GAP;
            end
            ST_GAP: if (t_done && mode_q == MODE_SYNC) begin
                t_load = 1'b1;
                if (!second) begin
                    t_val    = T_HALF;
                    sh_load  = 1'b1;
                    sh_sel_b = 1'b1;
                end else begin
                    t_val = T_LDW;
                end
            end
            ST_LDLO: if (t_done) begin
                t_load = 1'b1;
                t_val  = T_LDG;
            end
            default: ;
        endcase
    end

    assign cmd_ready = (state == ST_IDLE);
    assign pins      = pin_q;

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (pins.csn && !pins.sclk)) else $error("idle levels"); // R1
    AST_CS_RISE_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.csn) |-> !pins.sclk) else $error("cs rose with clock high"); // R5
    AST_LD_HIGH_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        (!pins.csn && mode_q == MODE_SYNC) |-> pins.ldacn) else $error("strobe low in frame"); // R7
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready) else $error("ready stayed high"); // R8

endmodule

// File: rtl/dacwr_ctrl.sv
module dacwr_ctrl
    import dacwr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int HALF_CYC  = 2,
    parameter int CS_HOLD   = 2,
    parameter int CS_GAP    = 2,
    parameter int LD_GAP    = 2,
    parameter int LD_W      = 2,
    parameter int BYTE_MODE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_sync,
    input  logic [1:0]        cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [DATA_W-1:0] cmd_data_b,
    output logic              dac_csn,
    output logic              dac_sclk,
    output logic              dac_sdi,
    output logic              dac_ldacn
);

    localparam int TOT_W = frame_len(DATA_W, BYTE_MODE);
    localparam int MAXV  = max5(HALF_CYC, CS_HOLD, CS_GAP, LD_GAP, LD_W);
    localparam int CNT_W = (MAXV > 1) ? $clog2(MAXV) : 1;

    upd_mode_t        mode_in;
    logic [TOT_W-1:0] word_a;
    logic [TOT_W-1:0] word_b_q;
    logic             accept;
    logic             t_load, t_done, sh_load, sh_sel_b, sh_adv, sh_last;
    logic [CNT_W-1:0] t_val;
    ctl_pins_t        pins;

    assign mode_in = upd_mode_t'(cmd_sync);
    assign accept  = cmd_valid && cmd_ready;
    assign word_a  = TOT_W'({(mode_in == MODE_SYNC) ? ADDR_A : cmd_addr, cmd_data});

    always_ff @(posedge clk) begin
        if (rst) begin
            word_b_q <= '0;
        end else if (accept) begin
            word_b_q <= TOT_W'({ADDR_B, cmd_data_b});
        end
    end

    dacwr_seq #(
        .HALF_CYC(HALF_CYC), .CS_HOLD(CS_HOLD), .CS_GAP(CS_GAP),
        .LD_GAP(LD_GAP), .LD_W(LD_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_mode(mode_in), .cmd_ready(cmd_ready),
        .t_done(t_done), .sh_last(sh_last),
        .t_load(t_load), .t_val(t_val),
        .sh_load(sh_load), .sh_sel_b(sh_sel_b), .sh_adv(sh_adv),
        .pins(pins)
    );

    dacwr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
    );

    dacwr_shifter #(.TOT_W(TOT_W)) u_shift (
        .clk(clk), .rst(rst), .load(sh_load),
        .load_word(sh_sel_b ? word_b_q : word_a),
        .advance(sh_adv), .sdi(dac_sdi), .last(sh_last)
    );

    assign dac_csn   = pins.csn;
    assign dac_sclk  = pins.sclk;
    assign dac_ldacn = pins.ldacn;

    AST_SDI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdi)) else $error("data moved in high phase"); // R3
    AST_SDI_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_sclk) |-> $stable(dac_sdi)) else $error("data moved at rising edge"); // R3

endmodule

// File: tb/sim_dacwr_ctrl.sv
module sim_mon #(
    parameter int HALF = 2,
    parameter int HOLD = 2,
    parameter int GAP  = 2,
    parameter int LDW  = 2
) (
    input  logic        clk,
    input  logic        clr,
    input  logic        csn,
    input  logic        sclk,
    input  logic        sdi,
    input  logic        ld,
    output int          nframes,
    output logic [31:0] fw0, fw1,
    output int          fb0, fb1,
    output logic        fld0, fld1,
    output int          ld_falls, ld_at,
    output int          v_setup, v_phase, v_cs, v_gap, v_ldw
);
    logic        p_csn = 1'b1, p_sclk = 1'b0, p_sdi = 1'b0, p_ld = 1'b1, seen_rise = 1'b0;
    logic [31:0] shreg = '1;
    int          bits = 0, lo_run = 0, hi_run = 0, cs_hi = 0, ld_lo = 0;

    initial begin
        nframes = 0; fw0 = 0; fw1 = 0; fb0 = 0; fb1 = 0; fld0 = 0; fld1 = 0;
        ld_falls = 0; ld_at = 0; v_setup = 0; v_phase = 0; v_cs = 0; v_gap = 0; v_ldw = 0;
    end

    always @(negedge clk) begin
        if (clr) begin
            nframes = 0; ld_falls = 0; ld_at = 0; seen_rise = 0;
            v_setup = 0; v_phase = 0; v_cs = 0; v_gap = 0; v_ldw = 0;
            bits = 0; shreg = '1;
        end else begin
            if (!p_sclk && sclk && !csn) begin
                if (sdi != p_sdi) v_setup++;
                if (lo_run < HALF) v_phase++;
                shreg = {shreg[30:0], sdi};
                bits++;
            end
            if (sclk && p_sclk && sdi != p_sdi) v_setup++;
            if (p_sclk && !sclk && hi_run < HALF) v_phase++;
            if (!p_csn && csn) begin
                if (sclk || lo_run < HOLD) v_cs++;
                if (nframes == 0) begin fw0 = shreg; fb0 = bits; fld0 = ld; end
                if (nframes == 1) begin fw1 = shreg; fb1 = bits; fld1 = ld; end
                nframes++;
                seen_rise = 1;
            end
            if (p_csn && !csn) begin
                if (seen_rise && cs_hi < GAP) v_gap++;
                bits = 0; shreg = '1;
            end
            if (p_ld && !ld) begin ld_falls++; ld_at = nframes; end
            if (!p_ld && ld && ld_lo < LDW) v_ldw++;
        end
        lo_run = sclk ? 0 : lo_run + 1;
        hi_run = sclk ? hi_run + 1 : 0;
        cs_hi  = csn ? cs_hi + 1 : 0;
        ld_lo  = ld ? 0 : ld_lo + 1;
        p_csn = csn; p_sclk = sclk; p_sdi = sdi; p_ld = ld;
    end
endmodule

module sim_dacwr_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        v0 = 1'b0, v1 = 1'b0, c_sync = 1'b0, clr = 1'b0;
    logic [1:0]  c_addr = 2'b00;
    logic [15:0] c_data = '0, c_data_b = '0;
    logic        rdy0, csn0, sclk0, sdi0, ld0;
    logic        rdy1, csn1, sclk1, sdi1, ld1;
    int          n_chk = 0, n_bad = 0, cyc = 0;

    always #2.5 clk = ~clk;

    dacwr_ctrl u0 (
        .clk(clk), .rst(rst), .cmd_valid(v0), .cmd_ready(rdy0), .cmd_sync(c_sync),
        .cmd_addr(c_addr), .cmd_data(c_data), .cmd_data_b(c_data_b),
        .dac_csn(csn0), .dac_sclk(sclk0), .dac_sdi(sdi0), .dac_ldacn(ld0)
    );
    dacwr_ctrl #(.BYTE_MODE(1)) u1 (
        .clk(clk), .rst(rst), .cmd_valid(v1), .cmd_ready(rdy1), .cmd_sync(c_sync),
        .cmd_addr(c_addr), .cmd_data(c_data), .cmd_data_b(c_data_b),
        .dac_csn(csn1), .dac_sclk(sclk1), .dac_sdi(sdi1), .dac_ldacn(ld1)
    );

    int          nf [2], fb0 [2], fb1 [2], lf [2], la [2];
    int          vs [2], vp [2], vc [2], vg [2], vl [2];
    logic [31:0] fw0 [2], fw1 [2];
    logic        fl0 [2], fl1 [2];

    sim_mon m0 (.clk(clk), .clr(clr), .csn(csn0), .sclk(sclk0), .sdi(sdi0), .ld(ld0),
        .nframes(nf[0]), .fw0(fw0[0]), .fw1(fw1[0]), .fb0(fb0[0]), .fb1(fb1[0]),
        .fld0(fl0[0]), .fld1(fl1[0]), .ld_falls(lf[0]), .ld_at(la[0]),
        .v_setup(vs[0]), .v_phase(vp[0]), .v_cs(vc[0]), .v_gap(vg[0]), .v_ldw(vl[0]));
    sim_mon m1 (.clk(clk), .clr(clr), .csn(csn1), .sclk(sclk1), .sdi(sdi1), .ld(ld1),
        .nframes(nf[1]), .fw0(fw0[1]), .fw1(fw1[1]), .fb0(fb0[1]), .fb1(fb1[1]),
        .fld0(fl0[1]), .fld1(fl1[1]), .ld_falls(lf[1]), .ld_at(la[1]),
        .v_setup(vs[1]), .v_phase(vp[1]), .v_cs(vc[1]), .v_gap(vg[1]), .v_ldw(vl[1]));

    task automatic chk(input bit ok, input string rq, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", rq, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int bits, input logic [1:0] a, input logic [15:0] d);
        return (32'hFFFF_FFFF << bits) | 32'({a, d});
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R8 watchdog got=%h exp=%h", cyc, 0);
            summary();
        end
    end

    function automatic logic rdy_of(input int w);
        return (w == 0) ? rdy0 : rdy1;
    endfunction

    // Issue one command to DUT w, hold valid with junk fields while busy, verify result.
    task automatic run_cmd(input int w, input logic sy, input logic [1:0] a,
                           input logic [15:0] d, input logic [15:0] db);
        int busy, bits, exp_busy;
        logic ldf;
        @(negedge clk); #1 clr = 1'b1;
        @(negedge clk); #1 clr = 1'b0;
        c_sync = sy; c_addr = a; c_data = d; c_data_b = db;
        if (w == 0) v0 = 1'b1; else v1 = 1'b1;
        @(negedge clk);
        chk(rdy_of(w) == 1'b0, "R8 ready low after accept", 32'(rdy_of(w)), 0);
        busy = 1;
        #1 c_sync = ~sy; c_addr = ~a; c_data = ~d; c_data_b = ~db;
        repeat (4) begin @(negedge clk); if (!rdy_of(w)) busy++; end
        #1 v0 = 1'b0; v1 = 1'b0;
        forever begin
            @(negedge clk);
            if (rdy_of(w)) break;
            busy++;
            if (busy > 5000) break;
        end
        bits = (w == 0) ? 18 : 24;
        exp_busy = sy ? (2 + 2 * (bits * 4 + 4) + 4) : (2 + bits * 4 + 4);
        chk(busy == exp_busy, "R8 busy length", 32'(busy), 32'(exp_busy));
        chk(vs[w] == 0, "R3 data stable around rising edge", 32'(vs[w]), 0);
        chk(vp[w] == 0, "R4 clock phase width", 32'(vp[w]), 0);
        chk(vc[w] == 0, "R5 chip select rise timing", 32'(vc[w]), 0);
        chk(vg[w] == 0, "R10 chip select high gap", 32'(vg[w]), 0);
        chk(fb0[w] == bits, (w == 0) ? "R2 frame bit count" : "R9 byte frame bit count",
            32'(fb0[w]), 32'(bits));
        ldf = (w == 0) ? ld0 : ld1;
        if (!sy) begin
            chk(nf[w] == 1, "R6 single frame", 32'(nf[w]), 1);
            chk(fw0[w] == exp_word(bits, a, d), (w == 0) ? "R6 frame content" : "R9 padded frame",
                fw0[w], exp_word(bits, a, d));
            chk(fl0[w] == 1'b0, "R6 strobe low at cs rise", 32'(fl0[w]), 0);
            chk(ldf == 1'b0, "R6 strobe held low after", 32'(ldf), 0);
        end else begin
            chk(nf[w] == 2, "R7 two frames", 32'(nf[w]), 2);
            chk(fw0[w] == exp_word(bits, 2'b01, d), "R7 channel A frame", fw0[w], exp_word(bits, 2'b01, d));
            chk(fw1[w] == exp_word(bits, 2'b10, db), "R7 channel B frame", fw1[w], exp_word(bits, 2'b10, db));
            chk(fb1[w] == bits, "R2 second frame bit count", 32'(fb1[w]), 32'(bits));
            chk(fl0[w] && fl1[w], "R7 strobe high at both cs rises", {30'd0, fl0[w], fl1[w]}, 32'h3);
            chk(lf[w] == 1 && la[w] == 2, "R7 one strobe pulse after frame B",
                32'(lf[w] * 16 + la[w]), 32'h12);
            chk(vl[w] == 0, "R7 strobe pulse width", 32'(vl[w]), 0);
            chk(ldf == 1'b1, "R7 strobe ends high", 32'(ldf), 1);
        end
    endtask

    // mode, addr, data, data_b
    localparam logic [34:0] VEC [8] = '{
        {1'b0, 2'b01, 16'hA5C3, 16'h0000},
        {1'b0, 2'b10, 16'h0001, 16'h0000},
        {1'b0, 2'b11, 16'hFFFF, 16'h0000},
        {1'b0, 2'b00, 16'h8000, 16'h0000},
        {1'b1, 2'b00, 16'h1234, 16'hFEDC},
        {1'b0, 2'b01, 16'h5A5A, 16'h0000},
        {1'b1, 2'b11, 16'h0000, 16'hFFFF},
        {1'b1, 2'b10, 16'h8001, 16'h7FFE}
    };

    initial begin
        repeat (3) @(negedge clk);
        chk(csn0 && !sclk0 && ld0 && rdy0, "R1 reset levels", {28'd0, csn0, sclk0, ld0, rdy0}, 32'hB);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(csn0 && !sclk0 && ld0 && rdy0, "R1 idle after reset", {28'd0, csn0, sclk0, ld0, rdy0}, 32'hB);

        for (int i = 0; i < 8; i++) begin
            run_cmd(0, VEC[i][34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0]);
        end

        // R9: byte-padded frames
        run_cmd(1, 1'b0, 2'b10, 16'hBEEF, 16'h0000);
        run_cmd(1, 1'b1, 2'b00, 16'hC001, 16'h0FF0);

        // R1: reset in the middle of a frame returns to idle levels
        @(negedge clk); #1 c_sync = 1'b1; v0 = 1'b1;
        @(negedge clk); #1 v0 = 1'b0;
        repeat (20) @(negedge clk);
        #1 rst = 1'b1;
        @(negedge clk);
        chk(csn0 && !sclk0 && ld0 && rdy0, "R1 mid-frame reset", {28'd0, csn0, sclk0, ld0, rdy0}, 32'hB);
        #1 rst = 1'b0;
        run_cmd(0, 1'b0, 2'b01, 16'h0F0F, 16'h0000);

        summary();
    end
endmodule